// File: doc/BRIEF.md
# Byte ALU with Status Flag Update

This block is the arithmetic stage of a small 8-bit processor datapath. Each cycle it takes an operation code, one or two operand bytes, an immediate byte, a flag index and the processor's present status byte. One clock later it presents the result byte, a high result byte for the 16-bit word add, a write-enable for the destination register, and the status byte the processor should hold afterwards. The register file and instruction sequencing are outside the block. The caller supplies operands and consumes the results.

Each operation updates only its own group of flags. Logic operations clear overflow. Increment and decrement flag overflow only when the result crosses the signed boundary. Compare updates the flags but leaves its register untouched. The word add treats the two operand bytes as one 16-bit register pair and adds a 6-bit constant to it. Single-bit operations set or clear one flag chosen by index.

Top module: `byte_alu`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `res_valid`, `res_write`, `res_lo`, `res_hi` and `status_out` are all zero.
- R2: The outputs reflect the operation presented with `op_valid` high exactly one clock edge later, with `res_valid` high. When `op_valid` is low, `res_valid` goes low at the next edge and all other outputs hold their values.
- R3: AND (op 1, a&b), XOR (op 2, a^b) and immediate AND (op 3, a&imm) write their result. They set Z (bit 1) when the result is zero and N (bit 2) from result bit 7. They clear V (bit 3). C (bit 0), H (bit 5), T (bit 6) and I (bit 7) keep their input values.
- R4: Every operation that updates S (bit 4) leaves S equal to N XOR V. These are ops 1 to 6 and op 8.
- R5: Increment (op 4) writes a+1 and sets V only when the result is 0x80. It updates Z, N and S and leaves C, H, T and I unchanged.
- R6: Decrement (op 5) writes a-1 and sets V only when the result is 0x7F. It updates Z, N and S and leaves C, H, T and I unchanged.
- R7: Compare (op 6) evaluates a-imm and does not write: `res_write` is 0 and `res_lo` equals a. It sets C when imm is greater than a taken as unsigned, and H on a borrow out of the low nibble. It sets V on signed overflow of the subtraction, sets Z and N from the difference, and leaves T and I unchanged.
- R8: Word add (op 8) adds imm[5:0] to the pair {b,a}, with a as the low byte, and ignores imm[7:6]. `res_lo` and `res_hi` carry the 16-bit sum. C is the carry out of bit 15, N is sum bit 15, Z marks a zero 16-bit sum, and V is set when bit 15 goes from 0 to 1. H, T and I are unchanged.
- R9: Nibble swap (op 7) writes {a[3:0],a[7:4]}, and move (op 0) writes b. Both leave the status byte unchanged.
- R10: Flag set (op 9) and flag clear (op 10) set or clear only the status bit whose index is `bit_sel`. The index order is C0, Z1, N2, V3, S4, H5, T6, I7. Neither writes a result.
- R11: Op codes 11 to 15 leave the status byte unchanged, do not write, and return a on `res_lo`.
- R12: For every operation except the word add, `res_hi` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 4 | Operation select |
| opnd_a | input | 8 | Destination operand, low byte of the word pair |
| opnd_b | input | 8 | Source operand, high byte of the word pair |
| imm | input | 8 | Immediate; the low 6 bits are the word-add constant |
| bit_sel | input | 3 | Flag index for set/clear |
| status_in | input | 8 | Current status byte |
| res_lo | output | 8 | Result byte (low byte of word add) |
| res_hi | output | 8 | High byte of word add result |
| res_write | output | 1 | Result should be written to the destination |
| res_valid | output | 1 | Outputs carry a new result |
| status_out | output | 8 | Next status byte |

## Verification
The assertions check on every cycle the rules that hold whatever the operands are. These are the one-cycle latency and hold, S tracking N XOR V, the flags each operation must preserve, compare never writing, single-flag operations touching at most one bit, and the signed-boundary rule for increment and decrement overflow. The exact result values and the operand-dependent flags can only be shown by the bench's directed scenarios. These include carry and borrow on compare, the 16-bit carry and sign transition of the word add, and the ignored upper immediate bits.

// File: rtl/balu_pkg.sv
package balu_pkg;
  localparam int FLAG_W = 8;
  localparam int FSEL_W = $clog2(FLAG_W);

  localparam int FC = 0;
  localparam int FZ = 1;
  localparam int FN = 2;
  localparam int FV = 3;
  localparam int FS = 4;
  localparam int FH = 5;
  localparam int FT = 6;
  localparam int FI = 7;

  typedef enum logic [3:0] {
    OP_MOVE = 4'd0,
    OP_AND  = 4'd1,
    OP_XOR  = 4'd2,
    OP_ANDI = 4'd3,
    OP_INC  = 4'd4,
    OP_DEC  = 4'd5,
    OP_CMP  = 4'd6,
    OP_SWAP = 4'd7,
    OP_WADD = 4'd8,
    OP_FSET = 4'd9,
    OP_FCLR = 4'd10
  } op_e;

  typedef enum logic [1:0] {
    LK_AND  = 2'd0,
    LK_XOR  = 2'd1,
    LK_ANDI = 2'd2
  } lkind_e;
endpackage

// File: rtl/balu_logic.sv
module balu_logic
  import balu_pkg::*;
#(
  parameter int DW = 8
) (
  input  lkind_e          kind,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  input  logic [DW-1:0]   imm,
  output logic [DW-1:0]   res,
  output logic            zf,
  output logic            nf
);
  always_comb begin
    unique case (kind)
      LK_XOR:  res = a ^ b;
      LK_ANDI: res = a & imm;
      default: res = a & b;
    endcase
  end

  assign zf = (res == '0);
  assign nf = res[DW-1];
endmodule

// File: rtl/balu_arith.sv
module balu_arith #(
  parameter int DW = 8
) (
  input  logic            is_sub,
  input  logic            use_imm,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   imm,
  output logic [DW-1:0]   res,
  output logic            cf,
  output logic            zf,
  output logic            nf,
  output logic            vf,
  output logic            hf
);
  localparam int HB = DW / 2;
  localparam logic [DW-1:0] ONE = DW'(1);
  localparam logic [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};

  logic [DW-1:0] b;
  logic [DW:0]   full;
  logic [HB:0]   half;

  assign b = use_imm ? imm : ONE;

  always_comb begin
    if (is_sub) full = {1'b0, a} - {1'b0, b};
    else        full = {1'b0, a} + {1'b0, b};
  end

  assign half = {1'b0, a[HB-1:0]} - {1'b0, b[HB-1:0]};
  assign res  = full[DW-1:0];
  assign cf   = full[DW];
  assign hf   = half[HB];
  assign zf   = (res == '0);
  assign nf   = res[DW-1];
  assign vf   = is_sub ? ((a[DW-1] ^ b[DW-1]) & (a[DW-1] ^ res[DW-1]))
                       : (~(a[DW-1] ^ b[DW-1]) & (a[DW-1] ^ res[DW-1]));

  always_comb begin
    if (!use_imm && !is_sub && vf)
      AST_INC_V_BOUNDARY: assert (res == SMIN); // R5
    if (!use_imm && is_sub && vf)
      AST_DEC_V_BOUNDARY: assert (res == SMAX); // R6
  end
endmodule

// File: rtl/balu_word.sv
module balu_word #(
  parameter int DW = 8,
  parameter int KW = 6
) (
  input  logic [DW-1:0]   lo,
  input  logic [DW-1:0]   hi,
  input  logic [KW-1:0]   k,
  output logic [DW-1:0]   sum_lo,
  output logic [DW-1:0]   sum_hi,
  output logic            cf,
  output logic            zf,
  output logic            nf,
  output logic            vf
);
  localparam int WW = 2 * DW;

  logic [WW:0] total;

  assign total  = {1'b0, hi, lo} + (WW + 1)'(k);
  assign sum_lo = total[DW-1:0];
  assign sum_hi = total[WW-1:DW];
  assign cf     = total[WW];
  assign nf     = total[WW-1];
  assign zf     = (total[WW-1:0] == '0);
  assign vf     = ~hi[DW-1] & total[WW-1];
endmodule

// File: rtl/byte_alu.sv
module byte_alu
  import balu_pkg::*;
#(
  parameter int DW = 8,
  parameter int KW = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                op_valid,
  input  logic [3:0]          op_code,
  input  logic [DW-1:0]       opnd_a,
  input  logic [DW-1:0]       opnd_b,
  input  logic [DW-1:0]       imm,
  input  logic [FSEL_W-1:0]   bit_sel,
  input  logic [FLAG_W-1:0]   status_in,
  output logic [DW-1:0]       res_lo,
  output logic [DW-1:0]       res_hi,
  output logic                res_write,
  output logic                res_valid,
  output logic [FLAG_W-1:0]   status_out
);
  localparam int HB = DW / 2;

  lkind_e        lk;
  logic [DW-1:0] l_res;
  logic          l_z, l_n;
  logic [DW-1:0] a_res;
  logic          a_c, a_z, a_n, a_v, a_h;
  logic          a_sub, a_imm;
  logic [DW-1:0] w_lo, w_hi;
  logic          w_c, w_z, w_n, w_v;

  always_comb begin
    unique case (op_code)
      OP_XOR:  lk = LK_XOR;
      OP_ANDI: lk = LK_ANDI;
      default: lk = LK_AND;
    endcase
  end

  assign a_sub = (op_code == OP_DEC) || (op_code == OP_CMP);
  assign a_imm = (op_code == OP_CMP);

  balu_logic #(.DW(DW)) u_logic (
    .kind(lk), .a(opnd_a), .b(opnd_b), .imm(imm),
    .res(l_res), .zf(l_z), .nf(l_n)
  );

  balu_arith #(.DW(DW)) u_arith (
    .is_sub(a_sub), .use_imm(a_imm), .a(opnd_a), .imm(imm),
    .res(a_res), .cf(a_c), .zf(a_z), .nf(a_n), .vf(a_v), .hf(a_h)
  );

  balu_word #(.DW(DW), .KW(KW)) u_word (
    .lo(opnd_a), .hi(opnd_b), .k(imm[KW-1:0]),
    .sum_lo(w_lo), .sum_hi(w_hi), .cf(w_c), .zf(w_z), .nf(w_n), .vf(w_v)
  );

  logic [DW-1:0]     nx_lo, nx_hi;
  logic              nx_wr, upd_s;
  logic [FLAG_W-1:0] nx_st;

  always_comb begin
    nx_lo = opnd_a;
    nx_hi = '0;
    nx_wr = 1'b0;
    nx_st = status_in;
    upd_s = 1'b0;
    case (op_code)
      OP_MOVE: begin
        nx_lo = opnd_b;
        nx_wr = 1'b1;
      end
      OP_AND, OP_XOR, OP_ANDI: begin
        nx_lo     = l_res;
        nx_wr     = 1'b1;
        nx_st[FZ] = l_z;
        nx_st[FN] = l_n;
        nx_st[FV] = 1'b0;
        upd_s     = 1'b1;
      end
      OP_INC, OP_DEC: begin
        nx_lo     = a_res;
        nx_wr     = 1'b1;
        nx_st[FZ] = a_z;
        nx_st[FN] = a_n;
        nx_st[FV] = a_v;
        upd_s     = 1'b1;
      end
      OP_CMP: begin
        nx_st[FC] = a_c;
        nx_st[FZ] = a_z;
        nx_st[FN] = a_n;
        nx_st[FV] = a_v;
        nx_st[FH] = a_h;
        upd_s     = 1'b1;
      end
      OP_SWAP: begin
        nx_lo = {opnd_a[HB-1:0], opnd_a[DW-1:HB]};
        nx_wr = 1'b1;
      end
      OP_WADD: begin
        nx_lo     = w_lo;
        nx_hi     = w_hi;
        nx_wr     = 1'b1;
        nx_st[FC] = w_c;
        nx_st[FZ] = w_z;
        nx_st[FN] = w_n;
        nx_st[FV] = w_v;
        upd_s     = 1'b1;
      end
      OP_FSET: nx_st[bit_sel] = 1'b1;
      OP_FCLR: nx_st[bit_sel] = 1'b0;
      default: ;
    endcase
    if (upd_s) nx_st[FS] = nx_st[FN] ^ nx_st[FV];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_lo     <= '0;
      res_hi     <= '0;
      res_write  <= 1'b0;
      res_valid  <= 1'b0;
      status_out <= '0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) begin
        res_lo     <= nx_lo;
        res_hi     <= nx_hi;
        res_write  <= nx_wr;
        status_out <= nx_st;
      end
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $fell(rst) |-> (!res_valid && !res_write && res_lo == '0 && res_hi == '0 && status_out == '0)); // R1

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> res_valid); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> (!res_valid && $stable(status_out) && $stable(res_lo) && $stable(res_hi) && $stable(res_write))); // R2

  AST_LOGIC_KEEP: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code inside {OP_AND, OP_XOR, OP_ANDI}) |=>
      (!status_out[FV] && status_out[FC] == $past(status_in[FC]) && status_out[FH] == $past(status_in[FH])
       && status_out[FT] == $past(status_in[FT]) && status_out[FI] == $past(status_in[FI]))); // R3

  AST_SIGN_RULE: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code inside {OP_AND, OP_XOR, OP_ANDI, OP_INC, OP_DEC, OP_CMP, OP_WADD}) |=>
      (status_out[FS] == (status_out[FN] ^ status_out[FV]))); // R4

  AST_STEP_KEEP_C: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code inside {OP_INC, OP_DEC}) |=>
      (status_out[FC] == $past(status_in[FC]) && status_out[FH] == $past(status_in[FH]))); // R5 R6

  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_CMP) |=> (!res_write && res_lo == $past(opnd_a))); // R7

  AST_WORD_KEEP: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_WADD) |=>
      (status_out[FH] == $past(status_in[FH]) && status_out[FT] == $past(status_in[FT])
       && status_out[FI] == $past(status_in[FI]))); // R8

  AST_NO_FLAG_TOUCH: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code inside {OP_MOVE, OP_SWAP}) |=> (status_out == $past(status_in))); // R9

  AST_SINGLE_BIT: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code inside {OP_FSET, OP_FCLR}) |=>
      ($countones(status_out ^ $past(status_in)) <= 1 && !res_write)); // R10

  AST_UNUSED_CODE: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code > OP_FCLR) |=>
      (status_out == $past(status_in) && !res_write && res_lo == $past(opnd_a))); // R11

  AST_HI_ZERO: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code != OP_WADD) |=> (res_hi == '0)); // R12
endmodule

// File: tb/byte_alu_test.sv
module byte_alu_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic [3:0] op_code = '0;
  logic [7:0] opnd_a = '0, opnd_b = '0, imm = '0;
  logic [2:0] bit_sel = '0;
  logic [7:0] status_in = '0;
  logic [7:0] res_lo, res_hi, status_out;
  logic       res_write, res_valid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  byte_alu uut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .imm(imm), .bit_sel(bit_sel),
    .status_in(status_in), .res_lo(res_lo), .res_hi(res_hi),
    .res_write(res_write), .res_valid(res_valid), .status_out(status_out)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Reference: returns {wr, hi, lo, status}
  function automatic logic [24:0] ref_op(input int op, input int a, input int b,
                                         input int k, input int sel, input int st);
    int lo = a, hi = 0, wr = 0, s = st, r, d;
    bit upd = 0;
    case (op)
      0: begin lo = b; wr = 1; end
      1, 2, 3: begin
        r = (op == 1) ? (a & b) : (op == 2) ? (a ^ b) : (a & k);
        lo = r; wr = 1;
        s[1] = (r == 0); s[2] = r[7]; s[3] = 0; upd = 1;
      end
      4: begin
        r = (a + 1) % 256; lo = r; wr = 1;
        s[1] = (r == 0); s[2] = r[7]; s[3] = (r == 128); upd = 1;
      end
      5: begin
        r = (a + 255) % 256; lo = r; wr = 1;
        s[1] = (r == 0); s[2] = r[7]; s[3] = (r == 127); upd = 1;
      end
      6: begin
        r = (a - k + 256) % 256;
        d = (a > 127 ? a - 256 : a) - (k > 127 ? k - 256 : k);
        s[0] = (k > a); s[5] = ((k % 16) > (a % 16));
        s[1] = (r == 0); s[2] = r[7]; s[3] = (d < -128 || d > 127); upd = 1;
      end
      7: begin lo = ((a % 16) * 16) + (a / 16); wr = 1; end
      8: begin
        r = b * 256 + a + (k % 64);
        lo = r % 256; hi = (r / 256) % 256; wr = 1;
        s[0] = (r > 65535); s[1] = ((r % 65536) == 0); s[2] = ((r % 65536) >= 32768);
        s[3] = (b < 128) && ((r % 65536) >= 32768); upd = 1;
      end
      9:  s[sel] = 1;
      10: s[sel] = 0;
      default: ;
    endcase
    if (upd) s[4] = s[2] ^ s[3];
    return {wr[0], hi[7:0], lo[7:0], s[7:0]};
  endfunction

  task automatic run_op(input string req, input int op, input int a, input int b,
                        input int k, input int sel, input int st);
    logic [24:0] e;
    e = ref_op(op, a, b, k, sel, st);
    @(negedge clk);
    op_valid = 1; op_code = op[3:0]; opnd_a = a[7:0]; opnd_b = b[7:0];
    imm = k[7:0]; bit_sel = sel[2:0]; status_in = st[7:0];
    @(posedge clk); #2;
    check("R2", "res_valid", int'(res_valid), 1);
    check(req, "res_lo", int'(res_lo), int'(e[15:8]));
    check((op == 8) ? req : "R12", "res_hi", int'(res_hi), int'(e[23:16]));
    check(req, "status", int'(status_out), int'(e[7:0]));
    check(req, "res_write", int'(res_write), int'(e[24]));
  endtask

  task automatic t_reset();
    #3;
    check("R1", "res_valid", int'(res_valid), 0);
    check("R1", "status", int'(status_out), 0);
    check("R1", "res_lo", int'(res_lo), 0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    @(posedge clk); #2;
    check("R1", "res_write after", int'(res_write), 0);
    check("R1", "res_hi after", int'(res_hi), 0);
  endtask

  task automatic t_logic();
    run_op("R3", 1, 8'hF0, 8'h8F, 0, 0, 8'h2B);
    run_op("R3", 2, 8'h5A, 8'h5A, 0, 0, 8'h00);
    run_op("R3", 3, 8'h3C, 8'h00, 8'hC3, 0, 8'hEF);
    run_op("R4", 2, 8'h0F, 8'hF0, 0, 0, 8'hC8);
  endtask

  task automatic t_step();
    run_op("R5", 4, 8'h7F, 0, 0, 0, 8'h00);
    run_op("R5", 4, 8'hFF, 0, 0, 0, 8'h21);
    run_op("R5", 4, 8'h10, 0, 0, 0, 8'h1F);
    run_op("R6", 5, 8'h80, 0, 0, 0, 8'h00);
    run_op("R6", 5, 8'h01, 0, 0, 0, 8'h21);
    run_op("R6", 5, 8'h00, 0, 0, 0, 8'h08);
  endtask

  task automatic t_compare();
    run_op("R7", 6, 8'h10, 0, 8'h20, 0, 8'hC0);
    run_op("R7", 6, 8'h20, 0, 8'h10, 0, 8'h3F);
    run_op("R7", 6, 8'h80, 0, 8'h01, 0, 8'h00);
    run_op("R7", 6, 8'h18, 0, 8'h09, 0, 8'h00);
    run_op("R7", 6, 8'h42, 0, 8'h42, 0, 8'h01);
  endtask

  task automatic t_word();
    run_op("R8", 8, 8'hFF, 8'h00, 8'h01, 0, 8'h00);
    run_op("R8", 8, 8'hFF, 8'hFF, 8'h01, 0, 8'hE0);
    run_op("R8", 8, 8'hFF, 8'h7F, 8'h3F, 0, 8'h00);
    run_op("R8", 8, 8'h10, 8'h20, 8'hFF, 0, 8'h01);
  endtask

  task automatic t_move_swap();
    run_op("R9", 7, 8'hA5, 8'h00, 0, 0, 8'h9C);
    run_op("R9", 0, 8'h11, 8'h77, 0, 0, 8'h63);
  endtask

  task automatic t_flags();
    run_op("R10", 9, 8'h00, 0, 0, 7, 8'h00);
    run_op("R10", 10, 8'h00, 0, 0, 0, 8'hFF);
    run_op("R10", 9, 8'h00, 0, 0, 3, 8'h08);
    run_op("R10", 10, 8'h00, 0, 0, 5, 8'hFF);
  endtask

  task automatic t_unused();
    run_op("R11", 11, 8'h3E, 8'h55, 8'hAA, 0, 8'h5A);
    run_op("R11", 15, 8'hC1, 8'h55, 8'hAA, 0, 8'hA5);
  endtask

  task automatic t_hold();
    logic [7:0] lo0, st0;
    run_op("R2", 4, 8'h41, 0, 0, 0, 8'h00);
    lo0 = res_lo; st0 = status_out;
    @(negedge clk);
    op_valid = 0; op_code = 4'd2; opnd_a = 8'hFF; opnd_b = 8'h0F; status_in = 8'hFF;
    @(posedge clk); #2;
    check("R2", "idle res_valid", int'(res_valid), 0);
    check("R2", "idle res_lo", int'(res_lo), int'(lo0));
    check("R2", "idle status", int'(status_out), int'(st0));
  endtask

  initial begin
    t_reset();
    t_logic();
    t_step();
    t_compare();
    t_word();
    t_move_swap();
    t_flags();
    t_unused();
    t_hold();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule